// File: doc/BRIEF.md
# Cascaded Programmable Output Divider

This block turns one fast clock into two slower clocks, both with a 50% duty cycle. The main output is the input clock divided by a ratio picked with a 2-bit code. The auxiliary output is the main output divided again by a ratio picked with a 1-bit code, so its total ratio against the input clock is the product of the two. It sits behind an oscillator in a clock tree, and software or strap pins pick the codes.

Both stages run in the input clock domain. The auxiliary stage advances only on the input edges where the main output rises, which keeps every auxiliary edge aligned with a main rising edge. When the main ratio is 1, the main output is the input clock gated by a run flag, so its duty cycle stays 50% without any counter. A new code is taken only when the stage it controls reaches the end of a full period, so switching ratios never produces a short pulse. An active-high asynchronous master reset clears both stages and holds both outputs low.

Top module: `cascadeDivider`

## Requirements
- R1: The main ratio code `nSel` selects the main period in input clock cycles: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R2: The main output is high for exactly half of its period. With ratio 1 it is high while the input clock is high, and for ratios 2, 4 and 8 it is high for 1, 2 and 4 input cycles from its rising edge.
- R3: The auxiliary output changes only on input edges where the main output rises. Its period is 4 main periods when `pSel` is 0 and 8 main periods when `pSel` is 1, so its period in input cycles is the main ratio times the auxiliary ratio.
- R4: The auxiliary output is high for exactly half of its period, starting at its rising edge.
- R5: While `rst` is high, both outputs are low, and asserting `rst` drives them low at once without waiting for a clock edge.
- R6: After `rst` falls, both outputs stay low until the next rising input edge, where both rise together and start their first full period with the codes present at that edge.
- R7: A change of `nSel` takes effect only at the end of the current main period. The period in progress completes with the old high and low times, and the next period uses the new ratio.
- R8: A change of `pSel` takes effect only at the end of the current auxiliary period. The period in progress completes with the old high and low times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Fast input clock being divided |
| rst | input | 1 | Asynchronous active-high master reset |
| nSel | input | 2 | Main ratio code (00:1, 01:2, 10:4, 11:8) |
| pSel | input | 1 | Auxiliary ratio code (0:4, 1:8) |
| mainOut | output | 1 | Input clock divided by the main ratio, 50% duty |
| auxOut | output | 1 | Main output divided by the auxiliary ratio, 50% duty |

## Verification
After `rst` falls, both outputs are due one rising input edge later. A new main code shows at the end of the main period in progress, so within eight input cycles. A new auxiliary code shows at the end of the auxiliary period in progress, so within 64 input cycles. After each ratio change the bench waits well past both bounds, then measures a full high and low phase of each output from its next rising edge, with timestamps taken on the output edges themselves. For the mid-period change tests, the measurement and the code change are anchored to the same rising edge, so the period that holds the change is the one compared against the old ratio, and the period after it is compared against the new one.

// File: rtl/cascadeDividerPkg.sv
package cascadeDividerPkg;

  // Strobes from the control stage to the output registers.
  typedef struct packed {
    logic mainSet;   // main output starts a new period (rising edge)
    logic mainClr;   // main output reaches its half period (falling edge)
    logic auxSet;    // auxiliary output rises
    logic auxClr;    // auxiliary output falls
    logic passMode;  // main ratio is 1: input clock is forwarded
    logic run;       // first edge after reset has been seen
  } divStrobe_t;

endpackage

// File: rtl/cascadeDividerCtrl.sv
module cascadeDividerCtrl
  import cascadeDividerPkg::*;
#(
  parameter int N_CODE_W   = 2,
  parameter int P_CODE_W   = 1,
  parameter int P_BASE_LOG = 2
) (
  input  logic                clkIn,
  input  logic                rst,
  input  logic [N_CODE_W-1:0] nSel,
  input  logic [P_CODE_W-1:0] pSel,
  output divStrobe_t          strb
);

  localparam int N_MAX_LOG = (1 << N_CODE_W) - 1;
  localparam int N_CNT_W   = (N_MAX_LOG > 0) ? N_MAX_LOG : 1;
  localparam int P_MAX_LOG = P_BASE_LOG + (1 << P_CODE_W) - 1;
  localparam int P_CNT_W   = (P_MAX_LOG > 0) ? P_MAX_LOG : 1;
  localparam logic [P_CNT_W-1:0] P_CNT_RST = P_CNT_W'((1 << P_BASE_LOG) - 1);

  logic [N_CODE_W-1:0] nCodeQ;
  logic [P_CODE_W-1:0] pCodeQ;
  logic [N_CNT_W-1:0]  nCnt;
  logic [P_CNT_W-1:0]  pCnt;
  logic                runQ;

  logic [N_CNT_W:0] nRatio, nHalf, nNext;
  logic [P_CNT_W:0] pRatio, pHalf, pNext;
  logic             nTerm, pTerm;

  // Active ratios come from the codes taken at the last terminal count (R1, R3).
  always_comb begin
    nRatio = (N_CNT_W + 1)'(1) << nCodeQ;
    nHalf  = nRatio >> 1;
    nNext  = {1'b0, nCnt} + 1'b1;
    nTerm  = (nNext == nRatio);
    pRatio = (P_CNT_W + 1)'(1) << (pCodeQ + P_BASE_LOG);
    pHalf  = pRatio >> 1;
    pNext  = {1'b0, pCnt} + 1'b1;
    pTerm  = (pNext == pRatio);
  end

  // Auxiliary stage only advances on main period starts (R3).
  always_comb begin
    strb.mainSet  = nTerm;
    strb.mainClr  = !nTerm && (nNext == nHalf);
    strb.auxSet   = nTerm && pTerm;
    strb.auxClr   = nTerm && !pTerm && (pNext == pHalf);
    strb.passMode = (nCodeQ == '0);
    strb.run      = runQ;
  end

  // Reset leaves both stages at their terminal count so the first edge starts
  // a full period on both outputs (R5, R6). New codes load only there (R7, R8).
  always_ff @(posedge clkIn or posedge rst) begin
    if (rst) begin
      nCodeQ <= '0;
      nCnt   <= '0;
      pCodeQ <= '0;
      pCnt   <= P_CNT_RST;
      runQ   <= 1'b0;
    end else begin
      runQ <= 1'b1;
      if (nTerm) begin
        nCnt   <= '0;
        nCodeQ <= nSel;
        if (pTerm) begin
          pCnt   <= '0;
          pCodeQ <= pSel;
        end else begin
          pCnt <= pCnt + 1'b1;
        end
      end else begin
        nCnt <= nCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cascadeDividerPath.sv
module cascadeDividerPath
  import cascadeDividerPkg::*;
(
  input  logic       clkIn,
  input  logic       rst,
  input  divStrobe_t strb,
  output logic       mainOut,
  output logic       auxOut
);

  logic mainQ;
  logic auxQ;

  always_ff @(posedge clkIn or posedge rst) begin
    if (rst) begin
      mainQ <= 1'b0;
    end else if (strb.mainSet) begin
      mainQ <= 1'b1;
    end else if (strb.mainClr) begin
      mainQ <= 1'b0;
    end
  end

  always_ff @(posedge clkIn or posedge rst) begin
    if (rst) begin
      auxQ <= 1'b0;
    end else if (strb.auxSet) begin
      auxQ <= 1'b1;
    end else if (strb.auxClr) begin
      auxQ <= 1'b0;
    end
  end

  // Ratio 1 forwards the input clock, gated off until the first edge (R2, R6).
  assign mainOut = strb.passMode ? (clkIn & strb.run) : mainQ;
  assign auxOut  = auxQ;

endmodule

// File: rtl/cascadeDivider.sv
module cascadeDivider
  import cascadeDividerPkg::*;
#(
  parameter int N_CODE_W   = 2,
  parameter int P_CODE_W   = 1,
  parameter int P_BASE_LOG = 2
) (
  input  logic                clkIn,
  input  logic                rst,
  input  logic [N_CODE_W-1:0] nSel,
  input  logic [P_CODE_W-1:0] pSel,
  output logic                mainOut,
  output logic                auxOut
);

  divStrobe_t strb;
  logic       strbPass;
  logic       strbRun;

  cascadeDividerCtrl #(
    .N_CODE_W  (N_CODE_W),
    .P_CODE_W  (P_CODE_W),
    .P_BASE_LOG(P_BASE_LOG)
  ) ctrlU (
    .clkIn(clkIn),
    .rst  (rst),
    .nSel (nSel),
    .pSel (pSel),
    .strb (strb)
  );

  cascadeDividerPath pathU (
    .clkIn  (clkIn),
    .rst    (rst),
    .strb   (strb),
    .mainOut(mainOut),
    .auxOut (auxOut)
  );

  assign strbPass = strb.passMode;
  assign strbRun  = strb.run;

endmodule

// File: rtl/cascadeDividerChk.sv
module cascadeDividerChk #(
  parameter int N_CODE_W   = 2,
  parameter int P_CODE_W   = 1,
  parameter int P_BASE_LOG = 2
) (
  input logic clkIn,
  input logic rst,
  input logic mainOut,
  input logic auxOut,
  input logic strbPass,
  input logic strbRun
);

  localparam int N_MAX_LOG     = (1 << N_CODE_W) - 1;
  localparam int P_MAX_LOG     = P_BASE_LOG + (1 << P_CODE_W) - 1;
  localparam int MAIN_HALF_MAX = (N_MAX_LOG > 0) ? (1 << (N_MAX_LOG - 1)) : 1;
  localparam int AUX_HALF_MAX  = ((1 << N_MAX_LOG) * (1 << P_MAX_LOG)) / 2;
  localparam int RUN_W         = $clog2(AUX_HALF_MAX + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_SAT = {RUN_W{1'b1}};

  logic             mainPrevQ, auxPrevQ;
  logic [RUN_W-1:0] mainRunQ, auxRunQ;

  // Run lengths of equal samples; main is only tracked when it is a register.
  always_ff @(posedge clkIn or posedge rst) begin
    if (rst) begin
      mainPrevQ <= 1'b0;
      mainRunQ  <= '0;
      auxPrevQ  <= 1'b0;
      auxRunQ   <= '0;
    end else begin
      if (strbPass) begin
        mainPrevQ <= 1'b0;
        mainRunQ  <= '0;
      end else begin
        mainPrevQ <= mainOut;
        if (mainOut != mainPrevQ) mainRunQ <= RUN_W'(1);
        else if (mainRunQ != RUN_SAT) mainRunQ <= mainRunQ + 1'b1;
      end
      auxPrevQ <= auxOut;
      if (auxOut != auxPrevQ) auxRunQ <= RUN_W'(1);
      else if (auxRunQ != RUN_SAT) auxRunQ <= auxRunQ + 1'b1;
    end
  end

  p_reset_quiet_r5: assert property (@(posedge clkIn)
    rst |-> (!auxOut && !mainOut && !strbRun))
    else $error("reset does not hold outputs low");

  p_aux_rise_on_main_r3: assert property (@(negedge clkIn) disable iff (rst)
    $rose(auxOut) |-> mainOut)
    else $error("auxiliary rise outside a main high phase");

  p_aux_fall_on_main_r3: assert property (@(negedge clkIn) disable iff (rst)
    $fell(auxOut) |-> mainOut)
    else $error("auxiliary fall outside a main high phase");

  p_main_half_bound_r2: assert property (@(posedge clkIn) disable iff (rst)
    mainRunQ <= RUN_W'(MAIN_HALF_MAX))
    else $error("main phase longer than largest half period");

  p_aux_half_bound_r4: assert property (@(posedge clkIn) disable iff (rst)
    auxRunQ <= RUN_W'(AUX_HALF_MAX))
    else $error("auxiliary phase longer than largest half period");

endmodule

bind cascadeDivider cascadeDividerChk #(
  .N_CODE_W  (N_CODE_W),
  .P_CODE_W  (P_CODE_W),
  .P_BASE_LOG(P_BASE_LOG)
) chkU (
  .clkIn   (clkIn),
  .rst     (rst),
  .mainOut (mainOut),
  .auxOut  (auxOut),
  .strbPass(strbPass),
  .strbRun (strbRun)
);

// File: tb/cascadeDivider_test.sv
module cascadeDivider_test;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct {
    bit    isAux;
    int    hiNs;
    int    loNs;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int  applied = 0;
  int  bad = 0;
  bit  done = 0;
  bit  go = 0;

  logic       clkIn = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] nSel = 2'b10;
  logic       pSel = 1'b0;
  wire        mainOut;
  wire        auxOut;

  cascadeDivider uut (
    .clkIn  (clkIn),
    .rst    (rst),
    .nSel   (nSel),
    .pSel   (pSel),
    .mainOut(mainOut),
    .auxOut (auxOut)
  );

  always #10 clkIn = ~clkIn;

  task automatic check(input string req, input string what, input int act, input int exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushItem(input bit isAux, input int hiNs, input int loNs, input string req);
    expItem_t it;
    it.isAux = isAux;
    it.hiNs  = hiNs;
    it.loNs  = loNs;
    it.req   = req;
    expQ.push_back(it);
  endtask

  // Monitor: measures one full period per queued item, from the next rising edge.
  initial begin
    forever begin
      wait (go);
      while (expQ.size() > 0) begin
        expItem_t it;
        realtime t0, t1, t2;
        it = expQ.pop_front();
        if (it.isAux) begin
          @(posedge auxOut); t0 = $realtime;
          @(negedge auxOut); t1 = $realtime;
          @(posedge auxOut); t2 = $realtime;
        end else begin
          @(posedge mainOut); t0 = $realtime;
          @(negedge mainOut); t1 = $realtime;
          @(posedge mainOut); t2 = $realtime;
        end
        check(it.req, it.isAux ? "aux high ns" : "main high ns", int'(t1 - t0), it.hiNs);
        check(it.req, it.isAux ? "aux low ns" : "main low ns", int'(t2 - t1), it.loNs);
      end
      go = 0;
    end
  end

  task automatic runMeasure();
    go = 1;
    wait (!go);
  endtask

  function automatic int mainHalfNs(input int code);
    return (code == 0) ? 10 : ((1 << code) / 2) * 20;
  endfunction

  function automatic int auxHalfNs(input int nCode, input int pCode);
    return (1 << nCode) * (4 << pCode) * 10;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
  endtask

  // Driver
  initial begin
    // R5: outputs low throughout reset
    repeat (3) @(negedge clkIn);
    check("R5", "mainOut in reset", int'(mainOut), 0);
    check("R5", "auxOut in reset", int'(auxOut), 0);

    // R6: release at a falling edge, both rise at the next rising edge
    rst = 1'b0;
    #1;
    check("R6", "mainOut before first edge", int'(mainOut), 0);
    check("R6", "auxOut before first edge", int'(auxOut), 0);
    @(posedge clkIn);
    #1;
    check("R6", "mainOut after first edge", int'(mainOut), 1);
    check("R6", "auxOut after first edge", int'(auxOut), 1);

    // R1 R2 R3 R4: all eight code combinations
    for (int n = 0; n < 4; n++) begin
      for (int p = 0; p < 2; p++) begin
        @(negedge clkIn);
        nSel = 2'(n);
        pSel = 1'(p);
        repeat (200) @(negedge clkIn);
        pushItem(1'b0, mainHalfNs(n), mainHalfNs(n), "R1 R2");
        pushItem(1'b1, auxHalfNs(n, p), auxHalfNs(n, p), "R3 R4");
        runMeasure();
      end
    end

    // R7: main code change in the middle of a ratio-8 period
    @(negedge clkIn);
    nSel = 2'b11;
    pSel = 1'b0;
    repeat (200) @(negedge clkIn);
    pushItem(1'b0, 80, 80, "R7");
    go = 1;
    @(posedge mainOut);
    #30 nSel = 2'b01;
    wait (!go);
    pushItem(1'b0, 20, 20, "R7");
    runMeasure();

    // R8: auxiliary code change in the middle of a ratio-8 period
    @(negedge clkIn);
    nSel = 2'b00;
    pSel = 1'b1;
    repeat (200) @(negedge clkIn);
    pushItem(1'b1, 80, 80, "R8");
    go = 1;
    @(posedge auxOut);
    #30 pSel = 1'b0;
    wait (!go);
    pushItem(1'b1, 40, 40, "R8");
    runMeasure();

    // R5: reset asserted mid-operation forces outputs low at once
    @(negedge clkIn);
    nSel = 2'b10;
    repeat (20) @(negedge clkIn);
    @(posedge mainOut);
    #3 rst = 1'b1;
    #1;
    check("R5", "mainOut after async reset", int'(mainOut), 0);
    check("R5", "auxOut after async reset", int'(auxOut), 0);
    repeat (4) @(negedge clkIn);
    rst = 1'b0;
    @(posedge clkIn);
    #1;
    check("R6", "mainOut after second release", int'(mainOut), 1);

    done = 1;
    summary();
    $finish;
  end

  // Watchdog
  initial begin
    #(200000 * 20);
    if (!done) begin
      applied++;
      bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule